// File: doc/BRIEF.md
# Filtered Performance Event Counter

This block is one performance counter together with the filter logic that turns raw per-cycle event activity into increments. Every cycle it sees a set of small scalar event counts, one bitmask-style event (a dispatch vector with one bit per execution port) and the privilege mode of the current cycle. A control word, loaded through a simple write port, chooses the event. It also selects which ports of the bitmask event count, which privilege modes may count, and how the chosen value becomes an increment.

With a zero threshold the counter adds the whole per-cycle value. With a non-zero threshold it adds one in every cycle whose value reaches the threshold, or with the invert bit set, in every cycle whose value stays below it. The edge option counts only the cycles in which the filtered condition rises. Software can then divide an ordinary cycle count by this burst count to get the mean burst length.

The counter can be loaded directly. When its top bit carries out, it raises a one-cycle overflow pulse, an optional interrupt request and an optional toggling pin. The reset input is asserted asynchronously and released through a two-stage synchronizer.

Top module: `evt_counter_top`

## Requirements
- R1: While reset is applied and after it is released with no activity, count, ovf_pulse, irq_req and ovf_pin are all 0.
- R2: Control bits [2:0] pick the event. Values 0..3 choose the scalar count evt_counts[3*k+2:3*k], value 4 chooses the bitmask event, and values 5..7 give a per-cycle value of 0.
- R3: For the bitmask event, the per-cycle value is the number of set bits in port_vec AND the unit mask in control bits [7:3] (bit i of the mask belongs to port i).
- R4: Control bits [10:8] enable counting in privilege modes 0 (user), 1 (supervisor) and 2 (hypervisor), one bit per mode in that order. Mode 3 never counts. In a disabled mode the count does not change.
- R5: With the threshold in control bits [13:11] equal to 0 and edge off, the counter adds the full per-cycle value, and the invert bit has no effect.
- R6: With a non-zero threshold and invert (bit 14) clear, the counter adds 1 in a cycle whose value is at least the threshold and 0 otherwise.
- R7: With a non-zero threshold and invert set, the counter adds 1 in a cycle whose value is below the threshold and 0 otherwise.
- R8: With edge (bit 15) set, the counter adds 1 only in a cycle where the filtered condition is true and was false in the previous cycle. The filtered condition is the mode enable AND the threshold test; at threshold 0 the test is "value non-zero".
- R9: A control write takes effect from the next cycle; counting in the write cycle uses the old settings. The write clears the edge history, so a condition that stays true across the write counts again in the following cycle.
- R10: cnt_we loads cnt_wdata into the counter and overrides any increment in that cycle.
- R11: When an increment carries out of the top counter bit, the counter keeps the low bits and ovf_pulse is 1 for exactly the cycle after that edge.
- R12: irq_req is 1 together with ovf_pulse when bit 16 was set at the time of the overflow, and 0 otherwise.
- R13: When bit 17 was set at the time of an overflow, ovf_pin toggles on that overflow; otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | CFG_W | Control word value |
| cnt_we | input | 1 | Counter load strobe |
| cnt_wdata | input | CTR_W | Counter load value |
| priv_mode | input | 2 | Privilege mode of this cycle |
| evt_counts | input | NUM_EVT*EVT_W | Packed scalar per-cycle event counts |
| port_vec | input | PORT_N | Per-cycle port dispatch bitmask |
| count | output | CTR_W | Current counter value |
| ovf_pulse | output | 1 | One-cycle overflow indication |
| irq_req | output | 1 | Overflow interrupt request |
| ovf_pin | output | 1 | Toggle output flipped per overflow |

## Verification
The bench sweeps every event select, threshold, invert and edge setting across all mode masks and privilege modes, so it catches an off-by-one in the threshold compare (counting at value equal to the threshold, or missing it) and an invert bit that leaks into threshold-zero mode. It holds an edge condition across a control rewrite: a design that forgets to clear the edge history misses that burst, and one that applies new settings in the write cycle adds a count too early. It loads near-wrap values to check that an overflow keeps the low bits, pulses for a single cycle and gates the interrupt and pin by the enables. It also checks that a load beats a concurrent increment.

// File: rtl/evt_pkg.sv
package evt_pkg;

  // Default geometry of one filtered counter.
  localparam int DEF_NUM_EVT = 4;
  localparam int DEF_EVT_W   = 3;
  localparam int DEF_PORT_N  = 5;
  localparam int DEF_CTR_W   = 48;

  // Privilege mode encoding seen on priv_mode.
  typedef enum logic [1:0] {
    PRIV_USER = 2'd0,
    PRIV_SUP  = 2'd1,
    PRIV_HYP  = 2'd2,
    PRIV_MACH = 2'd3
  } priv_e;

  localparam int MODE_N = 3;  // number of maskable privilege modes

endpackage

// File: rtl/evt_select.sv
module evt_select
  import evt_pkg::*;
#(
  parameter int NUM_EVT = DEF_NUM_EVT,
  parameter int EVT_W   = DEF_EVT_W,
  parameter int PORT_N  = DEF_PORT_N,
  parameter int SEL_W   = $clog2(NUM_EVT + 1)
) (
  input  logic [SEL_W-1:0]         sel,
  input  logic [PORT_N-1:0]        umask,
  input  logic [NUM_EVT*EVT_W-1:0] evt_counts,
  input  logic [PORT_N-1:0]        port_vec,
  output logic [EVT_W-1:0]         raw
);

  logic [EVT_W-1:0]  evt_arr [NUM_EVT];
  logic [PORT_N-1:0] masked;
  logic [EVT_W-1:0]  pop;
  logic [EVT_W-1:0]  scalar;

  // Unpack the scalar event lanes.
  for (genvar g = 0; g < NUM_EVT; g++) begin : g_lane
    assign evt_arr[g] = evt_counts[g*EVT_W +: EVT_W];
  end

  assign masked = port_vec & umask;

  // Population count of the unit-masked dispatch vector.
  always_comb begin
    pop = '0;
    for (int i = 0; i < PORT_N; i++) begin
      pop = pop + EVT_W'(masked[i]);
    end
  end

  // Scalar lane mux, written as a compare per lane.
  always_comb begin
    scalar = '0;
    for (int k = 0; k < NUM_EVT; k++) begin
      if (sel == SEL_W'(k)) begin
        scalar = evt_arr[k];
      end
    end
  end

  always_comb begin
    if (sel < SEL_W'(NUM_EVT)) begin
      raw = scalar;
    end else if (sel == SEL_W'(NUM_EVT)) begin
      raw = pop;
    end else begin
      raw = '0;
    end
  end

endmodule

// File: rtl/evt_filter.sv
module evt_filter
  import evt_pkg::*;
#(
  parameter int EVT_W = DEF_EVT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] raw,
  input  logic [EVT_W-1:0] thr,
  input  logic             inv,
  input  logic             edge_en,
  input  logic             mode_ok,
  input  logic             hist_clr,
  output logic [EVT_W-1:0] inc
);

  logic thr_zero;
  logic reach;
  logic cond;
  logic prev_q;
  logic prev_d;
  logic [EVT_W-1:0] level_inc;

  assign thr_zero = (thr == '0);
  assign reach    = (raw >= thr);

  // Filtered condition: mode enable combined with the threshold test.
  always_comb begin
    if (!mode_ok) begin
      cond = 1'b0;
    end else if (thr_zero) begin
      cond = (raw != '0);
    end else begin
      cond = reach ^ inv;
    end
  end

  always_comb begin
    if (!mode_ok) begin
      level_inc = '0;
    end else if (thr_zero) begin
      level_inc = raw;
    end else begin
      level_inc = EVT_W'(cond);
    end
  end

  always_comb begin
    if (edge_en) begin
      inc = EVT_W'(cond & ~prev_q);
    end else begin
      inc = level_inc;
    end
  end

  // Edge history next state.
  always_comb begin
    if (hist_clr) begin
      prev_d = 1'b0;
    end else begin
      prev_d = cond;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
    end
  end

endmodule

// File: rtl/evt_accum.sv
module evt_accum
  import evt_pkg::*;
#(
  parameter int CTR_W = DEF_CTR_W,
  parameter int INC_W = DEF_EVT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INC_W-1:0] inc,
  input  logic             load,
  input  logic [CTR_W-1:0] load_val,
  input  logic             irq_en,
  input  logic             pin_en,
  output logic [CTR_W-1:0] count,
  output logic             ovf_pulse,
  output logic             irq_req,
  output logic             ovf_pin
);

  logic [CTR_W:0]   sum;
  logic [CTR_W-1:0] count_q;
  logic [CTR_W-1:0] count_d;
  logic             count_en;
  logic             wrap;
  logic             ovf_q;
  logic             irq_q;
  logic             pin_q;
  logic             pin_d;

  assign sum = {1'b0, count_q} + (CTR_W + 1)'(inc);

  always_comb begin
    if (load) begin
      count_d = load_val;
      wrap    = 1'b0;
    end else begin
      count_d = sum[CTR_W-1:0];
      wrap    = sum[CTR_W];
    end
  end

  assign count_en = load | (inc != '0);
  assign pin_d    = pin_q ^ (wrap & pin_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (count_en) begin
      count_q <= count_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      irq_q <= 1'b0;
      pin_q <= 1'b0;
    end else begin
      ovf_q <= wrap;
      irq_q <= wrap & irq_en;
      pin_q <= pin_d;
    end
  end

  assign count     = count_q;
  assign ovf_pulse = ovf_q;
  assign irq_req   = irq_q;
  assign ovf_pin   = pin_q;

endmodule

// File: rtl/evt_counter_top.sv
module evt_counter_top
  import evt_pkg::*;
#(
  parameter int NUM_EVT = DEF_NUM_EVT,
  parameter int EVT_W   = DEF_EVT_W,
  parameter int PORT_N  = DEF_PORT_N,
  parameter int CTR_W   = DEF_CTR_W,
  localparam int SEL_W     = $clog2(NUM_EVT + 1),
  localparam int UMASK_LSB = SEL_W,
  localparam int MODE_LSB  = UMASK_LSB + PORT_N,
  localparam int THR_LSB   = MODE_LSB + MODE_N,
  localparam int INV_BIT   = THR_LSB + EVT_W,
  localparam int EDGE_BIT  = INV_BIT + 1,
  localparam int IRQ_BIT   = EDGE_BIT + 1,
  localparam int PIN_BIT   = IRQ_BIT + 1,
  localparam int CFG_W     = PIN_BIT + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [CFG_W-1:0]         cfg_wdata,
  input  logic                     cnt_we,
  input  logic [CTR_W-1:0]         cnt_wdata,
  input  logic [1:0]               priv_mode,
  input  logic [NUM_EVT*EVT_W-1:0] evt_counts,
  input  logic [PORT_N-1:0]        port_vec,
  output logic [CTR_W-1:0]         count,
  output logic                     ovf_pulse,
  output logic                     irq_req,
  output logic                     ovf_pin
);

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe[1];

  // Control register.
  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cfg_q <= '0;
    end else if (cfg_we) begin
      cfg_q <= cfg_wdata;
    end
  end

  // Privilege mode qualification.
  logic [MODE_N-1:0] mode_en;
  logic              mode_ok;

  assign mode_en = cfg_q[MODE_LSB +: MODE_N];

  always_comb begin
    mode_ok = 1'b0;
    for (int m = 0; m < MODE_N; m++) begin
      if (priv_mode == 2'(m)) begin
        mode_ok = mode_en[m];
      end
    end
  end

  logic [EVT_W-1:0] raw;
  logic [EVT_W-1:0] inc;

  evt_select #(
    .NUM_EVT (NUM_EVT),
    .EVT_W   (EVT_W),
    .PORT_N  (PORT_N),
    .SEL_W   (SEL_W)
  ) u_select (
    .sel        (cfg_q[SEL_W-1:0]),
    .umask      (cfg_q[UMASK_LSB +: PORT_N]),
    .evt_counts (evt_counts),
    .port_vec   (port_vec),
    .raw        (raw)
  );

  evt_filter #(
    .EVT_W (EVT_W)
  ) u_filter (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .raw      (raw),
    .thr      (cfg_q[THR_LSB +: EVT_W]),
    .inv      (cfg_q[INV_BIT]),
    .edge_en  (cfg_q[EDGE_BIT]),
    .mode_ok  (mode_ok),
    .hist_clr (cfg_we),
    .inc      (inc)
  );

  evt_accum #(
    .CTR_W (CTR_W),
    .INC_W (EVT_W)
  ) u_accum (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .inc       (inc),
    .load      (cnt_we),
    .load_val  (cnt_wdata),
    .irq_en    (cfg_q[IRQ_BIT]),
    .pin_en    (cfg_q[PIN_BIT]),
    .count     (count),
    .ovf_pulse (ovf_pulse),
    .irq_req   (irq_req),
    .ovf_pin   (ovf_pin)
  );

endmodule

// File: rtl/evt_counter_chk.sv
module evt_counter_chk #(
  parameter int CTR_W    = 48,
  parameter int CFG_W    = 18,
  parameter int MODE_LSB = 8,
  parameter int EDGE_BIT = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CFG_W-1:0] cfg_q,
  input logic [1:0]       priv_mode,
  input logic             cnt_we,
  input logic [CTR_W-1:0] cnt_wdata,
  input logic [CTR_W-1:0] count,
  input logic             ovf_pulse,
  input logic             irq_req,
  input logic             ovf_pin
);

  logic mode_off;
  assign mode_off = (priv_mode == 2'd3) || !cfg_q[MODE_LSB + 32'(priv_mode)];

  AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |=> !ovf_pulse);  // R11

  AST_IRQ_NEEDS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ovf_pulse);  // R12

  AST_PIN_ON_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_pin != $past(ovf_pin)) |-> ovf_pulse);  // R13

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> (count == $past(cnt_wdata)));  // R10

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_we && mode_off) |=> (count == $past(count)));  // R4

  AST_EDGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_we && cfg_q[EDGE_BIT]) |=> (CTR_W'(count - $past(count)) <= CTR_W'(1)));  // R8

endmodule

bind evt_counter_top evt_counter_chk #(
  .CTR_W    (CTR_W),
  .CFG_W    (CFG_W),
  .MODE_LSB (MODE_LSB),
  .EDGE_BIT (EDGE_BIT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .cfg_q     (cfg_q),
  .priv_mode (priv_mode),
  .cnt_we    (cnt_we),
  .cnt_wdata (cnt_wdata),
  .count     (count),
  .ovf_pulse (ovf_pulse),
  .irq_req   (irq_req),
  .ovf_pin   (ovf_pin)
);

// File: tb/sim_evt_counter_top.sv
module sim_evt_counter_top;

  localparam int CLK_P = 10;
  localparam int CW    = 8;    // small counter so overflow is reached often
  localparam int FW    = 18;   // control word width at defaults

  logic            clk;
  logic            rst_n;
  logic            cfg_we;
  logic [FW-1:0]   cfg_wdata;
  logic            cnt_we;
  logic [CW-1:0]   cnt_wdata;
  logic [1:0]      priv_mode;
  logic [11:0]     evt_counts;
  logic [4:0]      port_vec;
  logic [CW-1:0]   count;
  logic            ovf_pulse;
  logic            irq_req;
  logic            ovf_pin;

  evt_counter_top #(.CTR_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .priv_mode(priv_mode),
    .evt_counts(evt_counts), .port_vec(port_vec), .count(count),
    .ovf_pulse(ovf_pulse), .irq_req(irq_req), .ovf_pin(ovf_pin)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;

  // Bench model state
  logic [FW-1:0] m_cfg;
  logic [CW-1:0] m_cnt;
  logic          m_prev;
  logic          m_ovf, m_irq, m_pin;
  logic [15:0]   lf;

  task automatic check(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] lfsr(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  function automatic int value_of(input logic [FW-1:0] c, input logic [11:0] ev,
                                  input logic [4:0] pv);
    int sel = int'(c[2:0]);
    int p = 0;
    if (sel < 4) return int'(ev[sel*3 +: 3]);
    if (sel == 4) begin
      for (int i = 0; i < 5; i++) p += int'(pv[i] & c[3+i]);
      return p;
    end
    return 0;
  endfunction

  // One clock: drive at negedge, advance model, check at next negedge.
  task automatic step(input bit do_cfg, input logic [FW-1:0] cw,
                      input bit do_cnt, input logic [CW-1:0] lv,
                      input logic [11:0] ev, input logic [4:0] pv,
                      input logic [1:0] pr, input string tag);
    int v, thr, inc, sum;
    bit ok, cond;
    cfg_we = do_cfg; cfg_wdata = cw; cnt_we = do_cnt; cnt_wdata = lv;
    evt_counts = ev; port_vec = pv; priv_mode = pr;
    v   = value_of(m_cfg, ev, pv);
    ok  = (pr != 2'd3) && m_cfg[8 + int'(pr)];
    thr = int'(m_cfg[13:11]);
    if (!ok) cond = 0;
    else if (thr == 0) cond = (v != 0);
    else cond = (v >= thr) ^ m_cfg[14];
    if (m_cfg[15]) inc = (cond && !m_prev) ? 1 : 0;
    else if (!ok) inc = 0;
    else if (thr == 0) inc = v;
    else inc = cond ? 1 : 0;
    if (do_cnt) begin
      m_ovf = 0;
      m_cnt = lv;
    end else begin
      sum   = int'(m_cnt) + inc;
      m_ovf = (sum >= (1 << CW));
      m_cnt = CW'(sum);
    end
    m_irq  = m_ovf && m_cfg[16];
    if (m_ovf && m_cfg[17]) m_pin = ~m_pin;
    m_prev = do_cfg ? 1'b0 : cond;
    if (do_cfg) m_cfg = cw;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 0; cnt_we = 0;
    check(tag, count, m_cnt);
    check("R11", ovf_pulse, m_ovf);
    check("R12", irq_req, m_irq);
    check("R13", ovf_pin, m_pin);
  endtask

  function automatic string tag_for(input logic [FW-1:0] c, input logic [1:0] pr);
    if (pr == 2'd3 || !c[8 + int'(pr)]) return "R4";
    if (c[15]) return "R8";
    if (c[13:11] != 0) return c[14] ? "R7" : "R6";
    if (c[2:0] == 3'd4) return "R3";
    if (c[2:0] > 3'd4) return "R2";
    return "R5";
  endfunction

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [FW-1:0] cw;
    logic [11:0]   ev;
    logic [4:0]    pv;
    logic [1:0]    pr;
    rst_n = 0; cfg_we = 0; cfg_wdata = '0; cnt_we = 0; cnt_wdata = '0;
    priv_mode = 0; evt_counts = '0; port_vec = '0;
    m_cfg = '0; m_cnt = '0; m_prev = 0; m_ovf = 0; m_irq = 0; m_pin = 0;
    lf = 16'hACE1;
    repeat (3) @(negedge clk);
    check("R1", count, 0); check("R1", ovf_pulse, 0);
    check("R1", irq_req, 0); check("R1", ovf_pin, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1", count, 0); check("R1", ovf_pulse, 0);
    check("R1", irq_req, 0); check("R1", ovf_pin, 0);

    // R9: edge condition held across a control rewrite, events held constant.
    cw = '0; cw[2:0] = 3'd0; cw[10:8] = 3'b111; cw[13:11] = 3'd1; cw[15] = 1'b1;
    step(1, cw, 0, '0, 12'h003, 5'h0, 2'd0, "R9");   // write: old cfg counts nothing
    step(0, cw, 0, '0, 12'h003, 5'h0, 2'd0, "R9");   // rising: +1
    step(0, cw, 0, '0, 12'h003, 5'h0, 2'd0, "R9");   // held: +0
    step(1, cw, 0, '0, 12'h003, 5'h0, 2'd0, "R9");   // rewrite: +0, history cleared
    step(0, cw, 0, '0, 12'h003, 5'h0, 2'd0, "R9");   // counts again: +1
    check("R9", count, 2);

    // R10/R11/R12/R13: load near wrap, load beating an increment, then overflow.
    cw = '0; cw[10:8] = 3'b111; cw[16] = 1'b1; cw[17] = 1'b1;
    step(1, cw, 0, '0, 12'h000, 5'h0, 2'd0, "R9");
    step(0, cw, 1, 8'hFE, 12'h003, 5'h0, 2'd0, "R10");
    check("R10", count, 8'hFE);
    step(0, cw, 0, '0, 12'h003, 5'h0, 2'd0, "R11");
    check("R11", count, 8'h01); check("R11", ovf_pulse, 1);
    check("R12", irq_req, 1);   check("R13", ovf_pin, 1);
    step(0, cw, 0, '0, 12'h000, 5'h0, 2'd0, "R11");
    check("R11", ovf_pulse, 0);
    cw[16] = 1'b0; cw[17] = 1'b0;
    step(1, cw, 0, '0, 12'h000, 5'h0, 2'd0, "R12");
    step(0, cw, 1, 8'hFF, 12'h000, 5'h0, 2'd0, "R10");
    step(0, cw, 0, '0, 12'h002, 5'h0, 2'd0, "R11");
    check("R12", irq_req, 0); check("R13", ovf_pin, 1);

    // Sweep of select, threshold, invert, edge and mode mask.
    for (int sel = 0; sel < 8; sel++)
      for (int thr = 0; thr < 8; thr++)
        for (int iv = 0; iv < 2; iv++)
          for (int ed = 0; ed < 2; ed++)
            for (int md = 0; md < 8; md++) begin
              lf = lfsr(lf);
              cw = '0;
              cw[2:0] = 3'(sel); cw[7:3] = lf[4:0]; cw[10:8] = 3'(md);
              cw[13:11] = 3'(thr); cw[14] = 1'(iv); cw[15] = 1'(ed);
              cw[16] = lf[5]; cw[17] = lf[6];
              step(1, cw, 0, '0, 12'h000, 5'h0, 2'd0, "R9");
              for (int c = 0; c < 8; c++) begin
                lf = lfsr(lf); ev = lf[11:0];
                lf = lfsr(lf); pv = lf[4:0]; pr = lf[6:5];
                step(0, cw, 0, '0, ev, pv, pr, tag_for(cw, pr));
              end
            end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule